// File: doc/BRIEF.md
# Two-Stage Serial-Clock Rate Generator

This block derives the bit timing of a two-wire serial bus controller from a fast core clock. A single 7-bit rate word carries two factors: a 4-bit linear factor M and a 3-bit exponent N. The exponent stage emits an enable once every 2^(N+1) core clocks. The linear stage counts those enables and emits a sample tick on every (M+1)-th one. A ten-tick phase sequencer then builds each serial-clock bit from those ticks, so the serial clock runs at core_clk / (10 × (M+1) × 2^(N+1)). Every combination of M (0..15) and N (0..7) is legal.

The sequencer is a two-state machine. In PH_RELEASED the clock line is released (high). In PH_HELD it is driven low. The transition PH_RELEASED→PH_HELD is taken on tick 0 of a bit, and PH_HELD→PH_RELEASED is taken on tick 5. Single-cycle markers tell the byte engine when to act. The hold marker comes at tick 0, the data-shift marker at tick 1, the release marker at tick 5, the sample marker at tick 7 and the bit-end marker at tick 9.

A rate word written mid-bit is staged and only becomes active at the next bit boundary, so no runt clock pulse can appear. A soft clear returns all counters and the sequencer to their start state and makes the staged word active.

Top module: `twi_rate_gen`

## Requirements
- R1: The rate word holds M in bits 6:3 and N in bits 2:0.
- R2: Sample ticks on `tick_o` are spaced exactly (M+1)×2^(N+1) core clocks apart. Call this spacing T.
- R3: The `scl_o` fall-to-fall period equals 10×(M+1)×2^(N+1) core clocks for every M in 0..15 and N in 0..7.
- R4: `hold_o` pulses at tick 0 and `scl_o` is low from the next cycle onward. `release_o` pulses at tick 5, 5T after `hold_o`, and `scl_o` is high from the cycle after it.
- R5: `shift_o` pulses T after `hold_o`, `sample_o` pulses 7T after it, and `bit_end_o` pulses 9T after it. Each marker is one cycle wide and occurs once per bit.
- R6: A rate word written during a bit leaves the rest of that bit at the old timing. The next bit starts with the new tick spacing.
- R7: A rate word written in the same cycle as `bit_end_o` is used for the bit that follows immediately.
- R8: After reset, `scl_o` is high, all markers are low and M=N=0. The first `hold_o` appears in the second cycle after reset is released.
- R9: A one-cycle `soft_clr` sets `scl_o` high in the next cycle and makes the staged rate word active. The first `hold_o` then comes T−1 cycles after the cycle that follows the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous-free synchronous reset |
| soft_clr | input | 1 | Clears counters and phase, applies staged rate word |
| rate_wr | input | 1 | Write strobe for the rate word |
| rate_wdata | input | 7 | Rate word: M in 6:3, N in 2:0 |
| tick_o | output | 1 | Sample-tick enable, one cycle wide |
| scl_o | output | 1 | Serial clock level (0 = drive low, 1 = release) |
| hold_o | output | 1 | Tick-0 marker: start driving the clock low |
| shift_o | output | 1 | Tick-1 marker: change the data line |
| release_o | output | 1 | Tick-5 marker: release the clock |
| sample_o | output | 1 | Tick-7 marker: sample the data line |
| bit_end_o | output | 1 | Tick-9 marker: last tick of the bit |

## Verification
A rate-word write and the bit-boundary load of the active factors can fall in the same cycle. The bench provokes this by waiting until `bit_end_o` is high and asserting the write strobe in that very cycle. It then checks that the next tick-0 marker comes after the new tick spacing and not the old one. A soft clear can also coincide with a pending staged word. That case is judged by the delay to the first hold marker after the clear and by the bit period that follows.

// File: rtl/twi_rate_pkg.sv
package twi_rate_pkg;
    localparam int unsigned BIT_TICKS  = 10;
    localparam int unsigned PH_W       = $clog2(BIT_TICKS);
    localparam int unsigned AT_HOLD    = 0;
    localparam int unsigned AT_SHIFT   = 1;
    localparam int unsigned AT_RELEASE = 5;
    localparam int unsigned AT_SAMPLE  = 7;
    localparam int unsigned AT_LAST    = BIT_TICKS - 1;

    typedef enum logic {
        PH_RELEASED = 1'b0,
        PH_HELD     = 1'b1
    } scl_phase_e;
endpackage

// File: rtl/twi_rate_cfg.sv
module twi_rate_cfg #(
    parameter int unsigned MW = 4,
    parameter int unsigned NW = 3,
    localparam int unsigned CW = MW + NW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr,
    input  logic [CW-1:0] wdata,
    input  logic          bnd,
    output logic [MW-1:0] m_o,
    output logic [NW-1:0] n_o
);
    logic [MW-1:0] stg_m;
    logic [NW-1:0] stg_n;
    logic [MW-1:0] wr_m;
    logic [NW-1:0] wr_n;
    logic          load;

    assign wr_m = wdata[CW-1:NW];
    assign wr_n = wdata[NW-1:0];
    assign load = bnd | clr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_m <= '0;
            stg_n <= '0;
            m_o   <= '0;
            n_o   <= '0;
        end else begin
            if (wr) begin
                stg_m <= wr_m;
                stg_n <= wr_n;
            end
            if (load) begin
                m_o <= wr ? wr_m : stg_m;
                n_o <= wr ? wr_n : stg_n;
            end
        end
    end

    // R6: active factors move only on a bit boundary or a clear
    p_hold_midbit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(load) |-> ($stable(m_o) && $stable(n_o)));
endmodule

// File: rtl/twi_rate_prescale.sv
module twi_rate_prescale #(
    parameter int unsigned NW = 3,
    localparam int unsigned PW = 1 << NW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [NW-1:0] n,
    output logic          pre_en
);
    logic [PW-1:0] pcnt;
    logic [PW-1:0] lim;
    logic [NW:0]   sh;

    assign sh     = {1'b0, n} + 1'b1;
    assign lim    = ~({PW{1'b1}} << sh);
    assign pre_en = (pcnt == lim);

    always_ff @(posedge clk) begin
        if (!rst_n)      pcnt <= '0;
        else if (clr)    pcnt <= '0;
        else if (pre_en) pcnt <= '0;
        else             pcnt <= pcnt + 1'b1;
    end

    // R2: exponent counter never passes its limit
    p_pre_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pcnt <= lim);
endmodule

// File: rtl/twi_rate_linear.sv
module twi_rate_linear #(
    parameter int unsigned MW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          pre_en,
    input  logic [MW-1:0] m,
    output logic          tick
);
    logic [MW-1:0] mcnt;

    assign tick = pre_en && (mcnt == m);

    always_ff @(posedge clk) begin
        if (!rst_n)      mcnt <= '0;
        else if (clr)    mcnt <= '0;
        else if (pre_en) mcnt <= tick ? '0 : mcnt + 1'b1;
    end

    // R2: linear counter never passes M
    p_lin_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mcnt <= m);
endmodule

// File: rtl/twi_rate_phase.sv
module twi_rate_phase
    import twi_rate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic scl_o,
    output logic hold_o,
    output logic shift_o,
    output logic release_o,
    output logic sample_o,
    output logic last_o
);
    localparam logic [PH_W-1:0] K_HOLD    = PH_W'(AT_HOLD);
    localparam logic [PH_W-1:0] K_SHIFT   = PH_W'(AT_SHIFT);
    localparam logic [PH_W-1:0] K_RELEASE = PH_W'(AT_RELEASE);
    localparam logic [PH_W-1:0] K_SAMPLE  = PH_W'(AT_SAMPLE);
    localparam logic [PH_W-1:0] K_LAST    = PH_W'(AT_LAST);

    logic [PH_W-1:0] phc;
    scl_phase_e      state_q;
    scl_phase_e      state_d;

    always_comb begin
        hold_o    = tick && (phc == K_HOLD);
        shift_o   = tick && (phc == K_SHIFT);
        release_o = tick && (phc == K_RELEASE);
        sample_o  = tick && (phc == K_SAMPLE);
        last_o    = tick && (phc == K_LAST);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    phc <= '0;
        else if (clr)  phc <= '0;
        else if (tick) phc <= (phc == K_LAST) ? '0 : phc + 1'b1;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_RELEASED: if (hold_o)    state_d = PH_HELD;
            PH_HELD:     if (release_o) state_d = PH_RELEASED;
            default:     state_d = PH_RELEASED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)   state_q <= PH_RELEASED;
        else if (clr) state_q <= PH_RELEASED;
        else          state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            PH_HELD: scl_o = 1'b0;
            default: scl_o = 1'b1;
        endcase
    end

    // R4: clock falls only after a hold marker
    p_fall_after_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_o) |-> $past(hold_o));
    // R4: clock rises only after a release marker or a clear
    p_rise_after_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_o) |-> ($past(release_o) || $past(clr)));
    // R5: at most one marker per cycle
    p_one_marker_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hold_o, shift_o, release_o, sample_o, last_o}));
    // R9: clear releases the clock next cycle
    p_clr_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> scl_o);
endmodule

// File: rtl/twi_rate_gen.sv
module twi_rate_gen #(
    parameter int unsigned MW = 4,
    parameter int unsigned NW = 3,
    localparam int unsigned CW = MW + NW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_clr,
    input  logic          rate_wr,
    input  logic [CW-1:0] rate_wdata,
    output logic          tick_o,
    output logic          scl_o,
    output logic          hold_o,
    output logic          shift_o,
    output logic          release_o,
    output logic          sample_o,
    output logic          bit_end_o
);
    logic [MW-1:0] act_m;
    logic [NW-1:0] act_n;
    logic          pre_en;

    twi_rate_cfg #(.MW(MW), .NW(NW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .clr(soft_clr), .wr(rate_wr),
        .wdata(rate_wdata), .bnd(bit_end_o), .m_o(act_m), .n_o(act_n)
    );

    twi_rate_prescale #(.NW(NW)) u_pre (
        .clk(clk), .rst_n(rst_n), .clr(soft_clr), .n(act_n), .pre_en(pre_en)
    );

    twi_rate_linear #(.MW(MW)) u_lin (
        .clk(clk), .rst_n(rst_n), .clr(soft_clr), .pre_en(pre_en),
        .m(act_m), .tick(tick_o)
    );

    twi_rate_phase u_ph (
        .clk(clk), .rst_n(rst_n), .clr(soft_clr), .tick(tick_o),
        .scl_o(scl_o), .hold_o(hold_o), .shift_o(shift_o),
        .release_o(release_o), .sample_o(sample_o), .last_o(bit_end_o)
    );

    // R2: every sample tick lines up with an exponent-stage enable
    p_tick_on_pre_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> pre_en);
endmodule

// File: tb/tb_twi_rate_gen.sv
module tb_twi_rate_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       soft_clr = 1'b0;
    logic       rate_wr = 1'b0;
    logic [6:0] rate_wdata = '0;
    logic tick_o, scl_o, hold_o, shift_o, release_o, sample_o, bit_end_o;
    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    twi_rate_gen dut (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .rate_wr(rate_wr),
        .rate_wdata(rate_wdata), .tick_o(tick_o), .scl_o(scl_o),
        .hold_o(hold_o), .shift_o(shift_o), .release_o(release_o),
        .sample_o(sample_o), .bit_end_o(bit_end_o)
    );

    function automatic int period(input int m, input int n);
        return 10 * (m + 1) * (1 << (n + 1));
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_cfg(input int m, input int n);
        @(negedge clk);
        rate_wr = 1'b1;
        rate_wdata = {4'(m), 3'(n)};
        @(negedge clk);
        rate_wr = 1'b0;
    endtask

    task automatic wait_bit_end;
        do @(negedge clk); while (!bit_end_o);
    endtask

    task automatic wait_hold(output int t);
        do @(negedge clk); while (!hold_o);
        t = cyc;
    endtask

    task automatic wait_fall(output int t);
        bit p;
        p = scl_o;
        forever begin
            @(negedge clk);
            if (p && !scl_o) break;
            p = scl_o;
        end
        t = cyc;
    endtask

    task automatic measure(input int m, input int n, input string req);
        int t0, t1;
        set_cfg(m, n);
        wait_bit_end();
        wait_fall(t0);
        wait_fall(t1);
        chk(t1 - t0 == period(m, n), req, t1 - t0, period(m, n));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got %0d expected %0d", 190000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int k, ta, tb, tc, td, te, t0, t1;
        int p_sh, p_rl, p_sa, p_le, c_sh, c_rl, c_sa, c_le;
        repeat (3) @(negedge clk);
        // R8: reset state
        chk(scl_o == 1'b1, "R8 scl", scl_o, 1);
        chk({hold_o, shift_o, release_o, sample_o, bit_end_o, tick_o} == 6'b0,
            "R8 markers", {hold_o, shift_o, release_o, sample_o, bit_end_o}, 0);
        rst_n = 1'b1;
        k = 0;
        while (!hold_o) begin @(negedge clk); k++; end
        chk(k == 1, "R8 first hold", k, 1);

        // R2: tick spacing
        set_cfg(2, 1);
        wait_bit_end();
        do @(negedge clk); while (!tick_o);
        t0 = cyc;
        do @(negedge clk); while (!tick_o);
        t1 = cyc;
        chk(t1 - t0 == 12, "R2 tick spacing", t1 - t0, 12);

        // R3: sweeps
        for (int m = 0; m < 16; m++) measure(m, 0, "R3 sweep M");
        for (int n = 1; n < 8; n++) measure(0, n, "R3 sweep N");
        measure(5, 1, "R1 fields");
        measure(1, 6, "R1 fields");

        // R6: mid-bit write
        measure(1, 0, "R3");
        wait_hold(ta);
        @(negedge clk);
        set_cfg(3, 1);
        wait_bit_end();
        tb = cyc;
        chk(tb - ta == 36, "R6 old bit kept", tb - ta, 36);
        wait_hold(tc);
        chk(tc - tb == 16, "R6 new spacing", tc - tb, 16);
        wait_fall(t0);
        wait_fall(t1);
        chk(t1 - t0 == 160, "R6 new period", t1 - t0, 160);

        // R7: write coincident with bit end
        wait_bit_end();
        rate_wr = 1'b1;
        rate_wdata = {4'd0, 3'd2};
        td = cyc;
        @(negedge clk);
        rate_wr = 1'b0;
        wait_hold(te);
        chk(te - td == 8, "R7 bypass", te - td, 8);
        wait_fall(t0);
        wait_fall(t1);
        chk(t1 - t0 == 80, "R7 period", t1 - t0, 80);

        // R4 / R5: phase markers with T = 4
        measure(1, 0, "R3");
        wait_hold(ta);
        p_sh = -1; p_rl = -1; p_sa = -1; p_le = -1;
        c_sh = 0; c_rl = 0; c_sa = 0; c_le = 0;
        for (int i = 1; i < 40; i++) begin
            @(negedge clk);
            if (shift_o)   begin c_sh++; p_sh = i; end
            if (release_o) begin c_rl++; p_rl = i; end
            if (sample_o)  begin c_sa++; p_sa = i; end
            if (bit_end_o) begin c_le++; p_le = i; end
            if (i == 1)  chk(scl_o == 1'b0, "R4 low after hold", scl_o, 0);
            if (i == 20) chk(scl_o == 1'b0, "R4 low at release tick", scl_o, 0);
            if (i == 21) chk(scl_o == 1'b1, "R4 high after release", scl_o, 1);
        end
        chk(p_rl == 20 && c_rl == 1, "R4 release pos", p_rl, 20);
        chk(p_sh == 4 && c_sh == 1, "R5 shift pos", p_sh, 4);
        chk(p_sa == 28 && c_sa == 1, "R5 sample pos", p_sa, 28);
        chk(p_le == 36 && c_le == 1, "R5 bit end pos", p_le, 36);

        // R9: soft clear with a staged word
        wait_hold(ta);
        set_cfg(2, 0);
        soft_clr = 1'b1;
        @(negedge clk);
        soft_clr = 1'b0;
        chk(scl_o == 1'b1, "R9 scl released", scl_o, 1);
        k = 0;
        while (!hold_o) begin @(negedge clk); k++; end
        chk(k == 5, "R9 first hold", k, 5);
        wait_fall(t0);
        wait_fall(t1);
        chk(t1 - t0 == 60, "R9 period", t1 - t0, 60);

        // R3: largest setting
        measure(15, 7, "R3 max");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule